// File: doc/BRIEF.md
# Line Transfer Scheduler

This block sits in the memory clock domain of a camera-to-display frame buffer path. It watches the fill counts of two FIFOs: an ingress FIFO that camera pixels collect in, and an egress FIFO that feeds the display. When the memory controller says it is ready, the block decides whether the next burst should drain the ingress FIFO into memory or refill the egress FIFO from memory. It then issues a single-cycle request pulse for that burst.

The decision points are thresholds set by parameters, not the full or empty flags. A drain starts while the ingress FIFO still has headroom. A refill starts while the egress FIFO still holds enough words to keep the display fed. The fast memory side therefore finishes its burst before the slow side can overrun or underrun. Each request is followed by a wait for the controller's ready line to go low and then high again, so one burst is never requested twice.

Top module: `xfer_sched`

## Requirements
- R1: While `rst` is high, and on the first clock edge that samples it high, both `wr_burst` and `rd_burst` are 0, and the scheduler is put in its idle state.
- R2: In the idle state, a clock edge that samples `mem_ready`=1 and `in_level` >= WR_LEVEL (default 512) drives `wr_burst` high right after that edge.
- R3: An `in_level` one below WR_LEVEL (511 by default) never causes a write request.
- R4: In the idle state, a clock edge that samples `mem_ready`=1, a write condition that is false, `out_level` <= RD_LEVEL (default 384), and free egress space (EGR_DEPTH − `out_level`, default depth 1024) of at least LINE_WORDS (default 640) drives `rd_burst` high right after that edge. An `out_level` of 385 gives no read.
- R5: When the write and read conditions hold in the same cycle, only `wr_burst` is raised.
- R6: Each request pulse lasts exactly one clock, and the two pulses are never high together.
- R7: While `mem_ready` is 0 in the idle state, no request is issued, whatever the levels are.
- R8: After a request, no new request is issued until `mem_ready` has been sampled 0 and then 1. The first edge that samples it 1 again returns to idle, and a pending request is pulsed one clock after that.
- R9: The scheduler uses four states: idle, write issue, read issue, and wait for completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_ready | input | 1 | Memory controller can accept a burst |
| in_level | input | ING_W (11) | Word count of the ingress (camera-side) FIFO |
| out_level | input | EGR_W (11) | Word count of the egress (display-side) FIFO |
| wr_burst | output | 1 | One-clock request: move a line from the ingress FIFO into memory |
| rd_burst | output | 1 | One-clock request: move a line from memory into the egress FIFO |

## Verification
On every cycle the assertions check the pulse shape: each pulse is one clock wide and the two pulses are mutually exclusive. They also check that every pulse can be traced to the ready and level inputs on the previous edge, with write taking priority. A checker-side flag confirms that no request comes before the ready line has gone low and back high. The exact threshold edges (511 against 512, 384 against 385) need the bench's scenarios. So do the reset behaviour, the one-cycle re-issue latency after ready returns, and the quiet interval while ready stays high after a request.

// File: rtl/xfer_sched_pkg.sv
package xfer_sched_pkg;

  typedef enum logic [1:0] {
    SCH_IDLE   = 2'd0,
    SCH_ISS_WR = 2'd1,
    SCH_ISS_RD = 2'd2,
    SCH_WAIT   = 2'd3
  } sch_state_e;

endpackage

// File: rtl/xfer_sched_cmp.sv
// Threshold comparators: turn FIFO word counts into transfer-need flags.
module xfer_sched_cmp #(
  parameter int ING_W      = 11,
  parameter int EGR_W      = 11,
  parameter int EGR_DEPTH  = 1024,
  parameter int WR_LEVEL   = 512,
  parameter int RD_LEVEL   = 384,
  parameter int LINE_WORDS = 640
) (
  input  logic [ING_W-1:0] in_level,
  input  logic [EGR_W-1:0] out_level,
  output logic             need_wr,
  output logic             need_rd
);

  localparam logic [ING_W-1:0] WR_LIM  = ING_W'(WR_LEVEL);
  localparam logic [EGR_W-1:0] RD_LIM  = EGR_W'(RD_LEVEL);
  localparam logic [EGR_W:0]   DEPTH_X = (EGR_W+1)'(EGR_DEPTH);
  localparam logic [EGR_W:0]   LINE_X  = (EGR_W+1)'(LINE_WORDS);

  logic [EGR_W:0] egr_free;

  always_comb begin
    egr_free = DEPTH_X - {1'b0, out_level};
    need_wr  = (in_level >= WR_LIM);
    need_rd  = (out_level <= RD_LIM) && (egr_free >= LINE_X);
  end

endmodule

// File: rtl/xfer_sched_fsm.sv
// Four-state request sequencer with registered one-clock pulses.
module xfer_sched_fsm
  import xfer_sched_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mem_ready,
  input  logic need_wr,
  input  logic need_rd,
  output logic wr_burst,
  output logic rd_burst
);

  sch_state_e state_q, state_d;
  logic       low_seen_q, low_seen_d;

  always_comb begin
    state_d    = state_q;
    low_seen_d = low_seen_q;
    unique case (state_q)
      SCH_IDLE: begin
        low_seen_d = 1'b0;
        if (mem_ready && need_wr)      state_d = SCH_ISS_WR;
        else if (mem_ready && need_rd) state_d = SCH_ISS_RD;
      end
      SCH_ISS_WR, SCH_ISS_RD: begin
        low_seen_d = 1'b0;
        state_d    = SCH_WAIT;
      end
      SCH_WAIT: begin
        if (!mem_ready)      low_seen_d = 1'b1;
        else if (low_seen_q) state_d    = SCH_IDLE;
      end
      default: state_d = SCH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SCH_IDLE;
      low_seen_q <= 1'b0;
      wr_burst   <= 1'b0;
      rd_burst   <= 1'b0;
    end else begin
      state_q    <= state_d;
      low_seen_q <= low_seen_d;
      wr_burst   <= (state_d == SCH_ISS_WR);
      rd_burst   <= (state_d == SCH_ISS_RD);
    end
  end

endmodule

// File: rtl/xfer_sched.sv
module xfer_sched #(
  parameter int ING_DEPTH  = 1024,
  parameter int EGR_DEPTH  = 1024,
  parameter int WR_LEVEL   = 512,
  parameter int RD_LEVEL   = 384,
  parameter int LINE_WORDS = 640,
  localparam int ING_W     = $clog2(ING_DEPTH) + 1,
  localparam int EGR_W     = $clog2(EGR_DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mem_ready,
  input  logic [ING_W-1:0] in_level,
  input  logic [EGR_W-1:0] out_level,
  output logic             wr_burst,
  output logic             rd_burst
);

  logic need_wr, need_rd;

  xfer_sched_cmp #(
    .ING_W(ING_W), .EGR_W(EGR_W), .EGR_DEPTH(EGR_DEPTH),
    .WR_LEVEL(WR_LEVEL), .RD_LEVEL(RD_LEVEL), .LINE_WORDS(LINE_WORDS)
  ) u_cmp (
    .in_level(in_level), .out_level(out_level),
    .need_wr(need_wr), .need_rd(need_rd)
  );

  xfer_sched_fsm u_fsm (
    .clk(clk), .rst(rst), .mem_ready(mem_ready),
    .need_wr(need_wr), .need_rd(need_rd),
    .wr_burst(wr_burst), .rd_burst(rd_burst)
  );

endmodule

// File: rtl/xfer_sched_chk.sv
module xfer_sched_chk #(
  parameter int ING_W      = 11,
  parameter int EGR_W      = 11,
  parameter int EGR_DEPTH  = 1024,
  parameter int WR_LEVEL   = 512,
  parameter int RD_LEVEL   = 384,
  parameter int LINE_WORDS = 640
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_ready,
  input logic [ING_W-1:0] in_level,
  input logic [EGR_W-1:0] out_level,
  input logic             wr_burst,
  input logic             rd_burst
);

  logic wr_ok, rd_ok, armed_q, low_q;

  assign wr_ok = mem_ready && (int'(in_level) >= WR_LEVEL);
  assign rd_ok = mem_ready && !(int'(in_level) >= WR_LEVEL) &&
                 (int'(out_level) <= RD_LEVEL) &&
                 ((EGR_DEPTH - int'(out_level)) >= LINE_WORDS);

  // Independent model of the ready handshake between requests.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
      low_q   <= 1'b0;
    end else if (wr_burst || rd_burst) begin
      armed_q <= 1'b0;
      low_q   <= 1'b0;
    end else if (!mem_ready) begin
      low_q   <= 1'b1;
    end else if (low_q) begin
      armed_q <= 1'b1;
    end
  end

  AST_WR_ONE_CLK: assert property (@(posedge clk) disable iff (rst) wr_burst |=> !wr_burst); // R6
  AST_RD_ONE_CLK: assert property (@(posedge clk) disable iff (rst) rd_burst |=> !rd_burst); // R6
  AST_EXCLUSIVE:  assert property (@(posedge clk) disable iff (rst) !(wr_burst && rd_burst)); // R6
  AST_WR_CAUSE:   assert property (@(posedge clk) disable iff (rst) $rose(wr_burst) |-> $past(wr_ok)); // R2
  AST_RD_CAUSE:   assert property (@(posedge clk) disable iff (rst) $rose(rd_burst) |-> $past(rd_ok)); // R5
  AST_HANDSHAKE:  assert property (@(posedge clk) disable iff (rst) (wr_burst || rd_burst) |-> armed_q); // R8

endmodule

bind xfer_sched xfer_sched_chk #(
  .ING_W(ING_W), .EGR_W(EGR_W), .EGR_DEPTH(EGR_DEPTH),
  .WR_LEVEL(WR_LEVEL), .RD_LEVEL(RD_LEVEL), .LINE_WORDS(LINE_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .mem_ready(mem_ready), .in_level(in_level),
  .out_level(out_level), .wr_burst(wr_burst), .rd_burst(rd_burst)
);

// File: tb/xfer_sched_bench.sv
`timescale 1ns/1ps
module xfer_sched_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_ready = 1'b0;
  logic [10:0] in_level = '0;
  logic [10:0] out_level = 11'd1000;
  logic        wr_burst, rd_burst;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  xfer_sched u_xfer_sched (
    .clk(clk), .rst(rst), .mem_ready(mem_ready), .in_level(in_level),
    .out_level(out_level), .wr_burst(wr_burst), .rd_burst(rd_burst)
  );

  typedef struct packed {
    logic        rdy;
    logic [10:0] inl;
    logic [10:0] outl;
    logic        ew;
    logic        er;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 11'd512,  11'd1000, 1'b1, 1'b0},  // R2 at threshold
    '{1'b1, 11'd511,  11'd1000, 1'b0, 1'b0},  // R3 one below
    '{1'b1, 11'd0,    11'd384,  1'b0, 1'b1},  // R4 read at limit
    '{1'b1, 11'd0,    11'd385,  1'b0, 1'b0},  // R4 one above
    '{1'b1, 11'd600,  11'd0,    1'b1, 1'b0},  // R5 both, write wins
    '{1'b0, 11'd1024, 11'd0,    1'b0, 1'b0},  // R7 not ready
    '{1'b1, 11'd1024, 11'd1024, 1'b1, 1'b0},  // R2 full ingress
    '{1'b1, 11'd511,  11'd0,    1'b0, 1'b1}   // R4 empty egress
  };

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic [10:0] il, input logic [10:0] ol);
    mem_ready = r; in_level = il; out_level = ol;
  endtask

  // Bring the scheduler back to idle: ready low twice, then high twice.
  task automatic recover();
    drive(1'b0, 11'd0, 11'd1000);
    repeat (2) @(negedge clk);
    drive(1'b1, 11'd0, 11'd1000);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs low even when both needs are present
    drive(1'b1, 11'd1024, 11'd0);
    repeat (3) @(negedge clk);
    check("R1 wr in reset", wr_burst, 1'b0);
    check("R1 rd in reset", rd_burst, 1'b0);
    drive(1'b0, 11'd0, 11'd1000);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      drive(VECS[i].rdy, VECS[i].inl, VECS[i].outl);
      @(negedge clk);
      check($sformatf("R2/R4 vec%0d wr", i), wr_burst, VECS[i].ew);
      check($sformatf("R2/R4 vec%0d rd", i), rd_burst, VECS[i].er);
      @(negedge clk);
      check($sformatf("R6 vec%0d wr width", i), wr_burst, 1'b0);
      check($sformatf("R6 vec%0d rd width", i), rd_burst, 1'b0);
      recover();
    end

    // R8: ready stays high after a request, no second request
    drive(1'b1, 11'd1024, 11'd0);
    @(negedge clk);
    check("R8 first wr", wr_burst, 1'b1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R8 quiet wr", wr_burst, 1'b0);
      check("R8 quiet rd", rd_burst, 1'b0);
    end
    mem_ready = 1'b0;
    @(negedge clk);
    check("R7 low wr", wr_burst, 1'b0);
    mem_ready = 1'b1;
    @(negedge clk);  // edge here returns to idle
    check("R8 idle edge wr", wr_burst, 1'b0);
    @(negedge clk);
    check("R8 reissue wr", wr_burst, 1'b1);
    check("R5 reissue rd", rd_burst, 1'b0);

    // R1: reset in the middle of a wait; re-issue after release
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid wr", wr_burst, 1'b0);
    rst = 1'b0;
    drive(1'b1, 11'd0, 11'd100);
    @(negedge clk);
    check("R9 idle after reset rd", rd_burst, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule